// File: doc/BRIEF.md
# SMBus Host Controller Status Register

This block holds the status word of an SMBus host controller. Single-cycle event pulses from the host engine and the bus monitor set sticky bits. Software reads the 16-bit word and clears any sticky bit by writing a 1 to it. Two further bits are not stored: they show live busy levels taken straight from the controller and the bus.

Each group of sticky bits is gated by an enable. The gated bits are ORed into one interrupt request, and logic outside the block routes that request. The host-error bits share one enable. The alert, host-as-target match and snoop match bits each have their own enable.

The alert pin is asynchronous and active low. It passes through a synchronizer of `SYNC_STAGES` flops before it can set its bit. The alert bit can only be set while the alert-pin function is selected.

Top module: `smbh_stat_top`

## Requirements
- R1: After reset, every bit of the read data is 0 while both busy inputs are low.
- R2: Bits 15:12 and 7:6 always read 0, and writes to them have no effect.
- R3: Bit 11 shows `bus_busy` and bit 3 shows `host_busy` in the same cycle, and a write does not change either bit.
- R4: A pulse on `ev_timeout`, `ev_done`, `ev_nack`, `ev_abort`, `ev_hslv_match` or `ev_snoop_match` sets bit 5, 4, 2, 0, 9 or 8 respectively at the next clock edge. The bit then holds until software clears it.
- R5: A write with `reg_wr_en` high clears every sticky bit (10, 9, 8, 5, 4, 2, 1, 0) whose data bit is 1. Sticky bits whose data bit is 0 are unchanged.
- R6: When a set event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R7: Bit 1 (collision) is set only when `host_start` and `other_start` are high in the same cycle while `bus_busy` is low. A host start on a busy bus, or a start without a coinciding start from another master, leaves bit 1 unchanged.
- R8: Bit 10 is set only while `alert_sel` is high and the synchronized `alert_pin_n` is low. A low level on the pin sampled at one edge sets bit 10 at the edge `SYNC_STAGES` cycles later.
- R9: `irq` is high exactly when one of these holds: bits 5, 4, 2, 1 or 0 are set with `en_host` high; bit 10 is set with `en_alert` high; bit 9 is set with `en_hslv` high; or bit 8 is set with `en_snoop` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 16 | Write data; a 1 clears the matching sticky bit |
| reg_rd_data | output | 16 | Status word |
| bus_busy | input | 1 | Bus busy level (host or other master) |
| host_busy | input | 1 | Host controller busy level |
| host_start | input | 1 | Pulse: host issues a start |
| other_start | input | 1 | Pulse: another master starts a transaction |
| ev_done | input | 1 | Pulse: host cycle completed successfully |
| ev_nack | input | 1 | Pulse: target failed to acknowledge |
| ev_timeout | input | 1 | Pulse: clock held low beyond the timeout limit |
| ev_abort | input | 1 | Pulse: host transfer aborted by software |
| ev_hslv_match | input | 1 | Pulse: write cycle addressed to the host-as-target address finished |
| ev_snoop_match | input | 1 | Pulse: cycle to the snoop address finished |
| alert_sel | input | 1 | Alert-pin function selected |
| alert_pin_n | input | 1 | Asynchronous active-low alert pin |
| en_host | input | 1 | Shared enable for host-error bits |
| en_alert | input | 1 | Enable for the alert bit |
| en_hslv | input | 1 | Enable for the host-as-target match bit |
| en_snoop | input | 1 | Enable for the snoop match bit |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 rather than the default 2. With three stages, a check taken exactly one cycle too early on the alert path fails, so an off-by-one in the synchronizer depth is caught. The same stimulus also exercises set-versus-clear collisions, starts that coincide on both an idle and a busy bus, and every enable against its own source group.

// File: rtl/smbh_stat_pkg.sv
package smbh_stat_pkg;
  localparam int STAT_W = 16;
  typedef logic [STAT_W-1:0] stat_t;

  localparam int B_ABORT = 0;
  localparam int B_COLL  = 1;
  localparam int B_HBUSY = 3;
  localparam int B_NACK  = 2;
  localparam int B_DONE  = 4;
  localparam int B_TMO   = 5;
  localparam int B_SNOOP = 8;
  localparam int B_HSLV  = 9;
  localparam int B_ALERT = 10;
  localparam int B_BBUSY = 11;

  localparam stat_t HOST_GRP = stat_t'((1 << B_ABORT) | (1 << B_COLL) | (1 << B_NACK)
                                       | (1 << B_DONE) | (1 << B_TMO));
  localparam stat_t STICKY   = HOST_GRP | stat_t'((1 << B_SNOOP) | (1 << B_HSLV) | (1 << B_ALERT));
  localparam stat_t LIVE     = stat_t'((1 << B_HBUSY) | (1 << B_BBUSY));
  localparam stat_t RSVD     = ~(STICKY | LIVE);

  function automatic stat_t sticky_next(stat_t cur, stat_t set, stat_t clr);
    return STICKY & ((cur & ~clr) | set);
  endfunction

  function automatic logic irq_of(stat_t st, logic e_host, logic e_alert,
                                  logic e_hslv, logic e_snoop);
    return (e_host && |(st & HOST_GRP)) || (e_alert && st[B_ALERT])
        || (e_hslv && st[B_HSLV]) || (e_snoop && st[B_SNOOP]);
  endfunction
endpackage

// File: rtl/smbh_pin_sync.sv
module smbh_pin_sync #(
  parameter int  STAGES    = 2,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= IDLE_VAL;
          else        chain[0] <= pin_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= IDLE_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/smbh_stat_events.sv
module smbh_stat_events
  import smbh_stat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bus_busy,
  input  logic  host_start,
  input  logic  other_start,
  input  logic  ev_done,
  input  logic  ev_nack,
  input  logic  ev_timeout,
  input  logic  ev_abort,
  input  logic  ev_hslv_match,
  input  logic  ev_snoop_match,
  input  logic  alert_sel,
  input  logic  alert_sync_n,
  output stat_t set_vec
);
  logic coll_hit;
  logic alert_hit;

  assign coll_hit  = host_start && other_start && !bus_busy;
  assign alert_hit = alert_sel && !alert_sync_n;

  always_comb begin
    set_vec          = '0;
    set_vec[B_ABORT] = ev_abort;
    set_vec[B_COLL]  = coll_hit;
    set_vec[B_NACK]  = ev_nack;
    set_vec[B_DONE]  = ev_done;
    set_vec[B_TMO]   = ev_timeout;
    set_vec[B_SNOOP] = ev_snoop_match;
    set_vec[B_HSLV]  = ev_hslv_match;
    set_vec[B_ALERT] = alert_hit;
  end

  // R7: a start on a busy bus never raises the collision event
  a_r7_busy_no_coll: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !set_vec[B_COLL]);
  // R7: a lone host start raises no collision
  a_r7_lone_start: assert property (@(posedge clk) disable iff (!rst_n)
    !other_start |-> !set_vec[B_COLL]);
  // R8: alert cannot fire while the pin function is deselected
  a_r8_sel_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_sel |-> !set_vec[B_ALERT]);
endmodule

// File: rtl/smbh_stat_sticky.sv
module smbh_stat_sticky
  import smbh_stat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t set_vec,
  input  stat_t clr_vec,
  output stat_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= sticky_next(q, set_vec, clr_vec);
  end

  generate
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      if (STICKY[i]) begin : g_chk
        // R6: a set event wins over a simultaneous clear
        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
          set_vec[i] |=> q[i]);
        // R5: a clear without a set empties the bit
        a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
          (clr_vec[i] && !set_vec[i]) |=> !q[i]);
        // R4: with no set and no clear the bit holds
        a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
          (!clr_vec[i] && !set_vec[i]) |=> $stable(q[i]));
      end else begin : g_fixed
        // R2: non-sticky positions never store a 1
        a_r2_no_store: assert property (@(posedge clk) disable iff (!rst_n)
          !q[i]);
      end
    end
  endgenerate
endmodule

// File: rtl/smbh_stat_irq.sv
module smbh_stat_irq
  import smbh_stat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t status,
  input  logic  en_host,
  input  logic  en_alert,
  input  logic  en_hslv,
  input  logic  en_snoop,
  output logic  irq
);
  assign irq = irq_of(status, en_host, en_alert, en_hslv, en_snoop);

  // R9: no enable, no request
  a_r9_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_host && !en_alert && !en_hslv && !en_snoop) |-> !irq);
  // R9: an enabled pending host error always requests
  a_r9_host_req: assert property (@(posedge clk) disable iff (!rst_n)
    (en_host && (status & HOST_GRP) != '0) |-> irq);
endmodule

// File: rtl/smbh_stat_top.sv
module smbh_stat_top
  import smbh_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [15:0] reg_wr_data,
  output logic [15:0] reg_rd_data,
  input  logic        bus_busy,
  input  logic        host_busy,
  input  logic        host_start,
  input  logic        other_start,
  input  logic        ev_done,
  input  logic        ev_nack,
  input  logic        ev_timeout,
  input  logic        ev_abort,
  input  logic        ev_hslv_match,
  input  logic        ev_snoop_match,
  input  logic        alert_sel,
  input  logic        alert_pin_n,
  input  logic        en_host,
  input  logic        en_alert,
  input  logic        en_hslv,
  input  logic        en_snoop,
  output logic        irq
);
  stat_t set_vec;
  stat_t clr_vec;
  stat_t sticky_q;
  stat_t live_vec;
  logic  alert_sync_n;

  smbh_pin_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_alert_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(alert_pin_n), .pin_sync(alert_sync_n)
  );

  smbh_stat_events u_events (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy),
    .host_start(host_start), .other_start(other_start),
    .ev_done(ev_done), .ev_nack(ev_nack), .ev_timeout(ev_timeout),
    .ev_abort(ev_abort), .ev_hslv_match(ev_hslv_match),
    .ev_snoop_match(ev_snoop_match), .alert_sel(alert_sel),
    .alert_sync_n(alert_sync_n), .set_vec(set_vec)
  );

  assign clr_vec = reg_wr_en ? (stat_t'(reg_wr_data) & STICKY) : '0;

  smbh_stat_sticky u_sticky (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .q(sticky_q)
  );

  always_comb begin
    live_vec          = '0;
    live_vec[B_BBUSY] = bus_busy;
    live_vec[B_HBUSY] = host_busy;
  end

  assign reg_rd_data = sticky_q | live_vec;

  smbh_stat_irq u_irq (
    .clk(clk), .rst_n(rst_n), .status(sticky_q),
    .en_host(en_host), .en_alert(en_alert), .en_hslv(en_hslv), .en_snoop(en_snoop),
    .irq(irq)
  );

  // R2: reserved positions read zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data & RSVD) == '0);
  // R3: busy bits track their inputs
  a_r3_live_busy: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[B_BBUSY] == bus_busy && reg_rd_data[B_HBUSY] == host_busy);
  // R8: a synchronized low with the function selected shows on the next cycle
  a_r8_alert_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_sel && !alert_sync_n) |=> reg_rd_data[B_ALERT]);
endmodule

// File: tb/smbh_stat_top_tb.sv
module smbh_stat_top_tb;
  localparam int NS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 0;
  logic [15:0] reg_wr_data = '0;
  logic [15:0] reg_rd_data;
  logic bus_busy = 0, host_busy = 0, host_start = 0, other_start = 0;
  logic ev_done = 0, ev_nack = 0, ev_timeout = 0, ev_abort = 0;
  logic ev_hslv_match = 0, ev_snoop_match = 0;
  logic alert_sel = 0, alert_pin_n = 1;
  logic en_host = 0, en_alert = 0, en_hslv = 0, en_snoop = 0;
  logic irq;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  smbh_stat_top #(.SYNC_STAGES(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .bus_busy(bus_busy), .host_busy(host_busy),
    .host_start(host_start), .other_start(other_start), .ev_done(ev_done),
    .ev_nack(ev_nack), .ev_timeout(ev_timeout), .ev_abort(ev_abort),
    .ev_hslv_match(ev_hslv_match), .ev_snoop_match(ev_snoop_match),
    .alert_sel(alert_sel), .alert_pin_n(alert_pin_n), .en_host(en_host),
    .en_alert(en_alert), .en_hslv(en_hslv), .en_snoop(en_snoop), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: an integer status word and a queue for the pin delay
  int m_st = 0;
  bit m_q[$];

  always @(posedge clk) begin
    int setv;
    int clrv;
    bit old;
    if (!rst_n) begin
      m_st = 0;
      m_q.delete();
      for (int k = 0; k < NS; k++) m_q.push_back(1'b1);
    end else begin
      old = m_q.pop_front();
      m_q.push_back(alert_pin_n);
      setv = 0;
      if (ev_abort)        setv += 'h0001;
      if (host_start && other_start && !bus_busy) setv += 'h0002;
      if (ev_nack)         setv += 'h0004;
      if (ev_done)         setv += 'h0010;
      if (ev_timeout)      setv += 'h0020;
      if (ev_snoop_match)  setv += 'h0100;
      if (ev_hslv_match)   setv += 'h0200;
      if (alert_sel && !old) setv += 'h0400;
      clrv = reg_wr_en ? int'(reg_wr_data) : 0;
      m_st = ((m_st & ~clrv) | setv) & 'h0737;
    end
    #1;
    if (rst_n) begin
      int exp_rd;
      bit exp_irq;
      exp_rd = m_st + (bus_busy ? 'h0800 : 0) + (host_busy ? 'h0008 : 0);
      exp_irq = (en_host && (m_st & 'h37) != 0) || (en_alert && m_st[10])
             || (en_hslv && m_st[9]) || (en_snoop && m_st[8]);
      check((int'(reg_rd_data) & 'hF0C0) == 0, "R2 reserved", reg_rd_data, 0);
      check((int'(reg_rd_data) & 'h0808) == (exp_rd & 'h0808), "R3 busy bits",
            reg_rd_data, exp_rd);
      check(int'(reg_rd_data) == exp_rd, "R4 status word vs model", reg_rd_data, exp_rd);
      check(irq == exp_irq, "R9 irq vs model", irq, exp_irq);
    end
  end

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    reg_wr_en = 1; reg_wr_data = d;
    step();
    reg_wr_en = 0; reg_wr_data = '0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    check(reg_rd_data == 16'h0000 && irq == 0, "R1 reset value", reg_rd_data, 0);

    // R4: every pulsed source sets its bit and holds
    ev_done = 1; ev_nack = 1; ev_timeout = 1; ev_abort = 1;
    ev_hslv_match = 1; ev_snoop_match = 1;
    step();
    ev_done = 0; ev_nack = 0; ev_timeout = 0; ev_abort = 0;
    ev_hslv_match = 0; ev_snoop_match = 0;
    check(reg_rd_data == 16'h0335, "R4 event set", reg_rd_data, 'h0335);
    step(4);
    check(reg_rd_data == 16'h0335, "R4 hold", reg_rd_data, 'h0335);

    // R5: zeros keep bits, ones clear them
    wr(16'h0000);
    check(reg_rd_data == 16'h0335, "R5 zero write", reg_rd_data, 'h0335);
    wr(16'h0011);
    check(reg_rd_data == 16'h0324, "R5 partial clear", reg_rd_data, 'h0324);
    // R2: writes to reserved positions have no effect
    wr(16'hF0C0);
    check(reg_rd_data == 16'h0324, "R2 reserved write", reg_rd_data, 'h0324);
    wr(16'hFFFF);
    check(reg_rd_data == 16'h0000, "R5 full clear", reg_rd_data, 0);

    // R3: live busy bits, unaffected by writes
    bus_busy = 1; host_busy = 0;
    step();
    check(reg_rd_data == 16'h0800, "R3 bus busy", reg_rd_data, 'h0800);
    bus_busy = 0; host_busy = 1;
    wr(16'h0808);
    check(reg_rd_data == 16'h0008, "R3 host busy after write", reg_rd_data, 'h0008);
    host_busy = 0;
    step();
    check(reg_rd_data == 16'h0000, "R3 busy released", reg_rd_data, 0);

    // R6: set and clear in the same cycle leave the bit set
    ev_done = 1; reg_wr_en = 1; reg_wr_data = 16'h0010;
    step();
    ev_done = 0; reg_wr_en = 0; reg_wr_data = '0;
    check(reg_rd_data == 16'h0010, "R6 set wins", reg_rd_data, 'h0010);
    wr(16'h0010);
    check(reg_rd_data == 16'h0000, "R6 later clear", reg_rd_data, 0);

    // R7: collision only on coinciding starts with an idle bus
    host_start = 1;
    step();
    host_start = 0;
    check(reg_rd_data == 16'h0000, "R7 lone start", reg_rd_data, 0);
    host_start = 1; other_start = 1; bus_busy = 1;
    step();
    host_start = 0; other_start = 0;
    check(reg_rd_data == 16'h0800, "R7 busy bus", reg_rd_data, 'h0800);
    bus_busy = 0;
    host_start = 1; other_start = 1;
    step();
    host_start = 0; other_start = 0;
    check(reg_rd_data == 16'h0002, "R7 collision", reg_rd_data, 'h0002);
    wr(16'h0002);

    // R8: alert gated by select, delayed by the synchronizer
    alert_pin_n = 0;
    step(NS + 3);
    check(reg_rd_data[10] == 1'b0, "R8 deselected", reg_rd_data, 0);
    alert_pin_n = 1;
    step(NS + 1);
    alert_sel = 1;
    alert_pin_n = 0;
    step(NS);
    check(reg_rd_data[10] == 1'b0, "R8 not before latency", reg_rd_data, 0);
    step();
    check(reg_rd_data == 16'h0400, "R8 after latency", reg_rd_data, 'h0400);
    alert_pin_n = 1;
    step(NS + 1);
    wr(16'h0400);
    check(reg_rd_data == 16'h0000, "R8 cleared", reg_rd_data, 0);
    alert_sel = 0;

    // R9: interrupt gating
    ev_snoop_match = 1;
    step();
    ev_snoop_match = 0;
    check(irq == 0, "R9 no enables", irq, 0);
    en_hslv = 1;
    step();
    check(irq == 0, "R9 wrong enable", irq, 0);
    en_snoop = 1;
    step();
    check(irq == 1, "R9 snoop enable", irq, 1);
    wr(16'h0100);
    check(irq == 0, "R9 snoop cleared", irq, 0);
    ev_nack = 1;
    step();
    ev_nack = 0;
    check(irq == 0, "R9 host disabled", irq, 0);
    en_host = 1;
    step();
    check(irq == 1, "R9 host enabled", irq, 1);
    wr(16'h0004);
    check(irq == 0, "R9 host cleared", irq, 0);
    ev_timeout = 1;
    step();
    ev_timeout = 0;
    check(irq == 1, "R9 timeout shares enable", irq, 1);
    wr(16'h0020);

    step(2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule